// File: doc/BRIEF.md
# Double-Buffered Frame Base Address Registers

This block keeps the start addresses of the two frame buffers that feed a dual-panel display controller, one for the upper half and one for the lower half of the screen. Software programs each address through a small register port. What it writes lands in a pending copy. The display fetch engine only ever sees the active copy, and the active copy changes only at a frame boundary. Software can therefore prepare the next frame's buffer while the current frame is still being scanned out, and the picture never tears.

At each vertical sync strobe, while the controller is enabled, both pending addresses move to the active registers. The move sets a sticky update flag. If the update interrupt is enabled, the flag also raises an interrupt, so software knows it may program the following buffer. When the controller enable input turns on, the pending addresses are loaded immediately, so the first frame already uses the programmed buffers. The lower-panel address only matters when the dual-panel bit is set, and that bit is passed straight out to the fetch engine.

The register port is a plain single-cycle port: a write takes effect on the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally. No data stream crosses the block's edge, so no valid/ready pair is needed and there is no back-pressure.

Top module: `fbb_frame_base`

## Requirements
- R1: After reset, both active addresses, both pending addresses, the control bits and the update flag are zero, and `irq` is low.
- R2: A write to register 0 (upper) or register 1 (lower) stores the data with bits 2:0 forced to zero. A read of that register returns the stored pending value.
- R3: A write to a base register does not change `up_base` or `lo_base` until the next load event.
- R4: A one-cycle `vsync` while `ctrl_en` is high copies both pending addresses to `up_base`/`lo_base`. The new values are visible after that clock edge.
- R5: A `vsync` while `ctrl_en` is low copies nothing and does not set the update flag.
- R6: A low-to-high change of `ctrl_en` loads both pending addresses into the active outputs on that edge, without setting the update flag.
- R7: A vsync copy sets the update flag, which is bit 0 of register 3. The flag stays set until software writes register 3 with bit 0 = 1. Writing bit 0 = 0 has no effect. A copy and a clear in the same cycle leave the flag set.
- R8: `irq` is high exactly when the update flag is set and the interrupt-enable bit (register 2, bit 0) is 1.
- R9: Register 2, bit 1 is the dual-panel bit and drives `dual_panel`. Reads of registers 2 and 3 return zero in all unused bits.
- R10: The upper and lower registers are independent. A write to one never changes the other's pending or active value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 upper, 1 lower, 2 control, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (pending value for base registers) |
| vsync | input | 1 | One-cycle vertical sync strobe |
| ctrl_en | input | 1 | Display controller enable |
| up_base | output | 32 | Active upper-panel frame base address |
| lo_base | output | 32 | Active lower-panel frame base address |
| dual_panel | output | 1 | Dual-panel mode bit |
| irq | output | 1 | Update interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit address and 3 alignment bits. With these values the forced-zero low bits and every control and status field sit at the positions stated above. The vector walk steps through page flips with the controller on and off. It covers writes in the middle of a frame, a clear that lands in the same cycle as a copy, and an enable edge that loads without raising the flag. Directed tests then cover the reset state, a reset in the middle of a run, and the unused read bits.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    FBB_UP   = 2'd0,
    FBB_LO   = 2'd1,
    FBB_CTRL = 2'd2,
    FBB_STAT = 2'd3
  } fbb_reg_e;

  localparam int unsigned CTRL_IE_BIT   = 0;
  localparam int unsigned CTRL_DUAL_BIT = 1;
  localparam int unsigned STAT_UPD_BIT  = 0;
  localparam int unsigned NUM_PANELS    = 2;
endpackage

// File: rtl/fbb_regfile.sv
module fbb_regfile
  import fbb_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [AW-1:0]     wdata,
  input  logic              upd_flag,
  output logic [AW-1:0]     pend_up,
  output logic [AW-1:0]     pend_lo,
  output logic              ie,
  output logic              dual,
  output logic              stat_clr,
  output logic [AW-1:0]     rdata
);
  logic [AW-1:0] pend [NUM_PANELS];

  // R2 / R10: one pending register per panel, each with its own select
  for (genvar p = 0; p < NUM_PANELS; p++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[p] <= '0;
      end else if (wr && addr == REG_AW'(p)) begin
        pend[p] <= {wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
      end
    end
  end

  assign pend_up = pend[FBB_UP];
  assign pend_lo = pend[FBB_LO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie   <= 1'b0;
      dual <= 1'b0;
    end else if (wr && addr == FBB_CTRL) begin
      ie   <= wdata[CTRL_IE_BIT];
      dual <= wdata[CTRL_DUAL_BIT];
    end
  end

  assign stat_clr = wr && (addr == FBB_STAT) && wdata[STAT_UPD_BIT];

  always_comb begin
    rdata = '0;
    unique case (fbb_reg_e'(addr))
      FBB_UP:   rdata = pend[FBB_UP];
      FBB_LO:   rdata = pend[FBB_LO];
      FBB_CTRL: begin
        rdata[CTRL_IE_BIT]   = ie;
        rdata[CTRL_DUAL_BIT] = dual;
      end
      FBB_STAT: rdata[STAT_UPD_BIT] = upd_flag;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/fbb_shadow.sv
module fbb_shadow #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] pend,
  output logic [AW-1:0] active
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
    end else if (load) begin
      active <= pend;
    end
  end
endmodule

// File: rtl/fbb_status.sv
module fbb_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  // R7: set has priority over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

  assign irq = flag & ie;
endmodule

// File: rtl/fbb_frame_base.sv
module fbb_frame_base
  import fbb_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [AW-1:0]     reg_wdata,
  output logic [AW-1:0]     reg_rdata,
  input  logic              vsync,
  input  logic              ctrl_en,
  output logic [AW-1:0]     up_base,
  output logic [AW-1:0]     lo_base,
  output logic              dual_panel,
  output logic              irq
);
  logic [AW-1:0] pend_up, pend_lo;
  logic [AW-1:0] pend_v   [NUM_PANELS];
  logic [AW-1:0] active_v [NUM_PANELS];
  logic          ie, stat_clr, upd_flag;
  logic          en_q, en_rise, vs_copy, load;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= ctrl_en;
  end

  assign en_rise = ctrl_en & ~en_q;
  assign vs_copy = vsync & ctrl_en;
  assign load    = vs_copy | en_rise;

  fbb_regfile #(.AW(AW), .ALIGN(ALIGN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .upd_flag (upd_flag),
    .pend_up  (pend_up),
    .pend_lo  (pend_lo),
    .ie       (ie),
    .dual     (dual_panel),
    .stat_clr (stat_clr),
    .rdata    (reg_rdata)
  );

  assign pend_v[FBB_UP] = pend_up;
  assign pend_v[FBB_LO] = pend_lo;

  for (genvar p = 0; p < NUM_PANELS; p++) begin : g_active
    fbb_shadow #(.AW(AW)) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .pend   (pend_v[p]),
      .active (active_v[p])
    );
  end

  assign up_base = active_v[FBB_UP];
  assign lo_base = active_v[FBB_LO];

  fbb_status u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (vs_copy),
    .clr   (stat_clr),
    .ie    (ie),
    .flag  (upd_flag),
    .irq   (irq)
  );
endmodule

// File: rtl/fbb_frame_base_chk.sv
module fbb_frame_base_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          vsync,
  input logic          ctrl_en,
  input logic [AW-1:0] up_base,
  input logic [AW-1:0] lo_base,
  input logic          irq,
  input logic [AW-1:0] pend_up,
  input logic [AW-1:0] pend_lo,
  input logic          upd_flag
);
  logic en_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) en_seen <= 1'b0;
    else        en_seen <= ctrl_en;
  end

  assert_hold_mid_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(vsync && ctrl_en) && !(ctrl_en && !en_seen)) |=> ($stable(up_base) && $stable(lo_base)));

  assert_copy_on_vsync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && ctrl_en) |=> (up_base == $past(pend_up) && lo_base == $past(pend_lo)));

  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_base[ALIGN-1:0] == '0) && (lo_base[ALIGN-1:0] == '0));

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && ctrl_en) |=> upd_flag);

  assert_no_flag_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !upd_flag) |=> !upd_flag);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> upd_flag);
endmodule

bind fbb_frame_base fbb_frame_base_chk #(.AW(AW), .ALIGN(ALIGN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .vsync    (vsync),
  .ctrl_en  (ctrl_en),
  .up_base  (up_base),
  .lo_base  (lo_base),
  .irq      (irq),
  .pend_up  (pend_up),
  .pend_lo  (pend_lo),
  .upd_flag (upd_flag)
);

// File: tb/fbb_frame_base_tb.sv
module fbb_frame_base_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic        vs;
    logic        en;
    logic [31:0] eu;
    logic [31:0] el;
    logic        eirq;
    logic [31:0] erd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 32'h1000_0007, 1'b0, 1'b0, 32'h0,         32'h0,         1'b0, 32'h1000_0000, 8'd2},  // R2
    '{1'b1, 2'd1, 32'h2000_0005, 1'b0, 1'b0, 32'h0,         32'h0,         1'b0, 32'h2000_0000, 8'd10}, // R10
    '{1'b1, 2'd2, 32'h0000_0003, 1'b0, 1'b0, 32'h0,         32'h0,         1'b0, 32'h0000_0003, 8'd9},  // R9
    '{1'b0, 2'd3, 32'h0,         1'b0, 1'b1, 32'h1000_0000, 32'h2000_0000, 1'b0, 32'h0,         8'd6},  // R6
    '{1'b1, 2'd0, 32'h3000_0000, 1'b0, 1'b1, 32'h1000_0000, 32'h2000_0000, 1'b0, 32'h3000_0000, 8'd3},  // R3
    '{1'b0, 2'd3, 32'h0,         1'b1, 1'b1, 32'h3000_0000, 32'h2000_0000, 1'b1, 32'h1,         8'd4},  // R4
    '{1'b1, 2'd3, 32'h0,         1'b0, 1'b1, 32'h3000_0000, 32'h2000_0000, 1'b1, 32'h1,         8'd7},  // R7
    '{1'b1, 2'd3, 32'h1,         1'b0, 1'b1, 32'h3000_0000, 32'h2000_0000, 1'b0, 32'h0,         8'd7},  // R7
    '{1'b1, 2'd1, 32'h4000_000F, 1'b0, 1'b1, 32'h3000_0000, 32'h2000_0000, 1'b0, 32'h4000_0008, 8'd3},  // R3
    '{1'b1, 2'd3, 32'h1,         1'b1, 1'b1, 32'h3000_0000, 32'h4000_0008, 1'b1, 32'h1,         8'd7},  // R7
    '{1'b1, 2'd2, 32'h0000_0002, 1'b0, 1'b1, 32'h3000_0000, 32'h4000_0008, 1'b0, 32'h0000_0002, 8'd8},  // R8
    '{1'b1, 2'd0, 32'h5000_0000, 1'b0, 1'b0, 32'h3000_0000, 32'h4000_0008, 1'b0, 32'h5000_0000, 8'd3},  // R3
    '{1'b0, 2'd0, 32'h0,         1'b1, 1'b0, 32'h3000_0000, 32'h4000_0008, 1'b0, 32'h5000_0000, 8'd5},  // R5
    '{1'b0, 2'd3, 32'h0,         1'b0, 1'b0, 32'h3000_0000, 32'h4000_0008, 1'b0, 32'h1,         8'd7},  // R7
    '{1'b1, 2'd2, 32'h0000_0001, 1'b0, 1'b0, 32'h3000_0000, 32'h4000_0008, 1'b1, 32'h0000_0001, 8'd8},  // R8
    '{1'b1, 2'd3, 32'h1,         1'b0, 1'b0, 32'h3000_0000, 32'h4000_0008, 1'b0, 32'h0,         8'd7},  // R7
    '{1'b0, 2'd3, 32'h0,         1'b1, 1'b0, 32'h3000_0000, 32'h4000_0008, 1'b0, 32'h0,         8'd5},  // R5
    '{1'b0, 2'd3, 32'h0,         1'b0, 1'b1, 32'h5000_0000, 32'h4000_0008, 1'b0, 32'h0,         8'd6}   // R6
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [AW-1:0] reg_wdata;
  logic [AW-1:0] reg_rdata;
  logic          vsync;
  logic          ctrl_en;
  logic [AW-1:0] up_base, lo_base;
  logic          dual_panel, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbb_frame_base dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .vsync      (vsync),
    .ctrl_en    (ctrl_en),
    .up_base    (up_base),
    .lo_base    (lo_base),
    .dual_panel (dual_panel),
    .irq        (irq)
  );

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] a, input logic [31:0] d,
                       input logic vs, input logic en);
    reg_wr = w; reg_addr = a; reg_wdata = d; vsync = vs; ctrl_en = en;
  endtask

  // advance one edge; inputs change at negedge, results read at the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 2'd0, '0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1 up_base", up_base, 32'h0);
    check("R1 lo_base", lo_base, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1;
      check($sformatf("R1 rdata[%0d]", a), reg_rdata, 32'h0);
    end

    // vector walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].vs, VEC[i].en);
      tick();
      check($sformatf("R%0d vec%0d up_base", VEC[i].req, i), up_base, VEC[i].eu);
      check($sformatf("R%0d vec%0d lo_base", VEC[i].req, i), lo_base, VEC[i].el);
      check($sformatf("R%0d vec%0d irq", VEC[i].req, i), {31'b0, irq}, {31'b0, VEC[i].eirq});
      check($sformatf("R%0d vec%0d rdata", VEC[i].req, i), reg_rdata, VEC[i].erd);
    end

    // R9: unused control bits read as zero, dual-panel bit drives the pin
    drive(1'b1, 2'd2, 32'hFFFF_FFFE, 1'b0, 1'b1);
    tick();
    check("R9 ctrl readback", reg_rdata, 32'h2);
    check("R9 dual_panel", {31'b0, dual_panel}, 32'h1);
    drive(1'b1, 2'd2, 32'h0, 1'b0, 1'b1);
    tick();
    check("R9 dual_panel off", {31'b0, dual_panel}, 32'h0);

    // R10: writing lower leaves upper pending untouched
    drive(1'b1, 2'd1, 32'h7777_7777, 1'b0, 1'b1);
    tick();
    drive(1'b0, 2'd0, 32'h0, 1'b0, 1'b1);
    #1;
    check("R10 upper pending", reg_rdata, 32'h5000_0000);
    drive(1'b0, 2'd1, 32'h0, 1'b0, 1'b1);
    #1;
    check("R10 lower pending", reg_rdata, 32'h7777_7770);

    // R7: status read shows unused bits zero after a copy
    drive(1'b0, 2'd3, 32'h0, 1'b1, 1'b1);
    tick();
    check("R7 status after copy", reg_rdata, 32'h1);
    check("R4 lo_base copy", lo_base, 32'h7777_7770);

    // R1: reset in the middle of a run clears everything
    drive(1'b0, 2'd3, 32'h0, 1'b0, 1'b0);
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    check("R1 up_base mid reset", up_base, 32'h0);
    check("R1 lo_base mid reset", lo_base, 32'h0);
    check("R1 status mid reset", reg_rdata, 32'h0);
    reg_addr = 2'd1;
    #1;
    check("R1 lower pending mid reset", reg_rdata, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule